// File: doc/BRIEF.md
# Serial Bus Frame Header Receiver

This block is the slave-side decoder for the header of a frame on a multi-master serial bus. A bit-recovery stage in front of it delivers one decoded line bit per strobe, plus a frame-start marker and the frame's broadcast flag. The receiver walks the header fields in a fixed order: master address, slave address, control code and message length. It checks the even parity of each field and decides, slot by slot, whether to pull the line low as an acknowledge.

Several checks can end reception early: a parity failure, an address that does not concern this unit, or a control code it cannot serve. In each case the receiver stays silent and falls back to monitoring the bus until the next frame start. When a header is accepted, the decoded fields are presented together with a one-cycle completion pulse.

The bit input carries a strobe only. There is no ready signal and no back-pressure, because a serial line cannot be paused. Every strobe is consumed in the cycle in which it is high.

Top module: `hdr_frame_rx`

## Requirements
- R1: A `frame_start` pulse in any state abandons the current header and restarts at the master address. The broadcast flag is sampled with it. If `in_valid` is high in the same cycle, that bit is the first master-address bit. Fields arrive MSB first: 12 master-address bits, then its parity bit; 12 slave-address bits, then its parity bit and an acknowledge slot; 4 control bits, then parity and an acknowledge slot; 8 length bits, then parity and an acknowledge slot.
- R2: Parity is even: the ones in a field plus its parity bit form an even count. If either address parity is wrong, the slave-address slot gets no acknowledge, no later slot is acknowledged, and no completion pulse follows.
- R3: In a non-broadcast frame, the slave-address slot is acknowledged only when the slave address equals `own_addr` and both address parities are correct. Otherwise the receiver returns to monitoring.
- R4: In a broadcast frame, a slave address of 0xFFF is a general broadcast and is accepted. Any other value is a group broadcast, whose group number is slave-address bits [11:8]. A group broadcast is accepted only if that group equals `own_addr[11:8]`. No slot of a broadcast frame is ever acknowledged.
- R5: The control slot is acknowledged only when the control parity is correct and the code is supported. With the default mask 0xFFDB, codes 2 and 5 are unsupported and all others are supported. On failure the receiver returns to monitoring.
- R6: A broadcast frame with correct control parity and a supported code moves on to the length field without an acknowledge.
- R7: The length slot is acknowledged in a non-broadcast frame when the length parity is correct. A wrong length parity gives no acknowledge and no completion pulse.
- R8: `ack_out` is high only in a cycle where `in_valid` is high in an acknowledge slot that is to be acknowledged. It is combinational within that strobe cycle.
- R9: `hdr_done` pulses for one cycle, in the cycle after the length acknowledge strobe. The `hdr_*` outputs change at that same edge and hold until the next pulse. `hdr_len_bytes` equals the length value, except that 0 means 256. `hdr_group` is 0 unless the frame is a group broadcast.
- R10: A `frame_start` in the cycle where `hdr_done` is high starts the next frame. The pulse and the held fields of the finished header are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 12 | This unit's address |
| frame_start | input | 1 | Start-of-frame marker |
| frame_bcast | input | 1 | Broadcast flag of the starting frame, sampled with frame_start |
| in_valid | input | 1 | Bit strobe |
| in_bit | input | 1 | Recovered line bit |
| ack_out | output | 1 | Drive acknowledge (pull line low) in this strobe |
| hdr_done | output | 1 | One-cycle pulse: header accepted |
| hdr_master | output | 12 | Master address |
| hdr_slave | output | 12 | Slave address |
| hdr_bcast | output | 1 | Frame was broadcast |
| hdr_general | output | 1 | Frame was a general broadcast |
| hdr_group | output | 4 | Group number of a group broadcast, else 0 |
| hdr_ctrl | output | 4 | Control code |
| hdr_len_bytes | output | 9 | Message length in bytes (1 to 256) |

## Verification
Two events can fall in the same cycle: the completion pulse of one header and the frame-start marker of the next frame. The bench sends headers back to back and drives the next `frame_start` in exactly the cycle where `hdr_done` is high. It then judges that the pulse was still counted with the first header's fields, and that the second header decodes correctly. A related collision, a restart in the middle of a header, is provoked by issuing `frame_start` partway through the master address. It is judged by a clean decode of the frame that follows.

// File: rtl/hdr_rx_pkg.sv
package hdr_rx_pkg;
  typedef enum logic [3:0] {
    ST_MON,
    ST_MADR, ST_MPAR,
    ST_SADR, ST_SPAR, ST_SACK,
    ST_CTL,  ST_CPAR, ST_CACK,
    ST_LEN,  ST_LPAR, ST_LACK
  } rx_state_e;

  function automatic logic is_data_state(rx_state_e s);
    return (s == ST_MADR) || (s == ST_SADR) || (s == ST_CTL) || (s == ST_LEN);
  endfunction

  function automatic logic is_par_state(rx_state_e s);
    return (s == ST_MPAR) || (s == ST_SPAR) || (s == ST_CPAR) || (s == ST_LPAR);
  endfunction

  function automatic logic is_ack_state(rx_state_e s);
    return (s == ST_SACK) || (s == ST_CACK) || (s == ST_LACK);
  endfunction
endpackage

// File: rtl/hdr_bit_shifter.sv
module hdr_bit_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] value,
  output logic         parity_ok
);
  logic [W-1:0] shreg;
  logic         par_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      par_acc <= 1'b0;
    end else if (clr && shift) begin
      shreg   <= {{(W-1){1'b0}}, bit_in};
      par_acc <= bit_in;
    end else if (clr) begin
      shreg   <= '0;
      par_acc <= 1'b0;
    end else if (shift) begin
      shreg   <= {shreg[W-2:0], bit_in};
      par_acc <= par_acc ^ bit_in;
    end
  end

  // bit_in is the parity bit when this is consulted: even total of ones
  assign parity_ok = ~(par_acc ^ bit_in);
  assign value     = shreg;
endmodule

// File: rtl/hdr_accept.sv
module hdr_accept #(
  parameter int ADDR_W = 12,
  parameter int GRP_W  = 4,
  parameter int CTRL_W = 4,
  parameter logic [2**CTRL_W-1:0] CTRL_OK_MASK = 16'hFFDB
) (
  input  logic              bcast,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [CTRL_W-1:0] ctrl_code,
  output logic              addr_accept,
  output logic              is_general,
  output logic [GRP_W-1:0]  group_id,
  output logic              ctrl_supported
);
  logic group_hit;
  logic unicast_hit;

  assign is_general     = bcast && (&slave_addr);
  assign group_hit      = slave_addr[ADDR_W-1 -: GRP_W] == own_addr[ADDR_W-1 -: GRP_W];
  assign unicast_hit    = slave_addr == own_addr;
  assign addr_accept    = bcast ? (is_general || group_hit) : unicast_hit;
  assign group_id       = (bcast && !is_general) ? slave_addr[ADDR_W-1 -: GRP_W] : '0;
  assign ctrl_supported = CTRL_OK_MASK[ctrl_code];
endmodule

// File: rtl/hdr_rx_seq.sv
module hdr_rx_seq
  import hdr_rx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 4,
  parameter int LEN_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_bcast,
  input  logic in_valid,
  input  logic par_ok,
  input  logic addr_accept,
  input  logic ctrl_supported,
  output logic shift_en,
  output logic clr,
  output logic cap_master,
  output logic cap_slave,
  output logic cap_ctrl,
  output logic cap_len,
  output logic done_load,
  output logic done_pulse,
  output logic bcast_q,
  output logic ack_out
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_CTL = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] LAST_LEN = CNT_W'(LEN_W - 1);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             m_ok;
  logic             ack_en;
  logic             step;
  logic [CNT_W-1:0] last_idx;

  assign step = in_valid && !frame_start;

  always_comb begin
    unique case (st)
      ST_CTL:  last_idx = LAST_CTL;
      ST_LEN:  last_idx = LAST_LEN;
      default: last_idx = LAST_ADR;
    endcase
  end

  assign shift_en   = in_valid && (frame_start || is_data_state(st));
  assign clr        = frame_start || (in_valid && is_par_state(st));
  assign cap_master = step && (st == ST_MPAR);
  assign cap_slave  = step && (st == ST_SPAR);
  assign cap_ctrl   = step && (st == ST_CPAR);
  assign cap_len    = step && (st == ST_LPAR);
  assign done_load  = step && (st == ST_LACK);
  assign ack_out    = step && ack_en && is_ack_state(st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_MON;
      cnt        <= '0;
      m_ok       <= 1'b0;
      ack_en     <= 1'b0;
      bcast_q    <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (frame_start) begin
        bcast_q <= frame_bcast;
        ack_en  <= 1'b0;
        st      <= ST_MADR;
        cnt     <= in_valid ? CNT_W'(1) : '0;
      end else if (in_valid) begin
        unique case (st)
          ST_MADR, ST_SADR, ST_CTL, ST_LEN: begin
            if (cnt == last_idx) begin
              cnt <= '0;
              unique case (st)
                ST_MADR: st <= ST_MPAR;
                ST_SADR: st <= ST_SPAR;
                ST_CTL:  st <= ST_CPAR;
                default: st <= ST_LPAR;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_MPAR: begin
            m_ok <= par_ok;
            st   <= ST_SADR;
          end
          ST_SPAR: begin
            if (m_ok && par_ok && addr_accept) begin
              st     <= ST_SACK;
              ack_en <= !bcast_q;
            end else begin
              st     <= ST_MON;
              ack_en <= 1'b0;
            end
          end
          ST_SACK: st <= ST_CTL;
          ST_CPAR: begin
            if (par_ok && ctrl_supported) begin
              st     <= ST_CACK;
              ack_en <= !bcast_q;
            end else begin
              st     <= ST_MON;
              ack_en <= 1'b0;
            end
          end
          ST_CACK: st <= ST_LEN;
          ST_LPAR: begin
            if (par_ok) begin
              st     <= ST_LACK;
              ack_en <= !bcast_q;
            end else begin
              st     <= ST_MON;
              ack_en <= 1'b0;
            end
          end
          ST_LACK: begin
            st         <= ST_MON;
            ack_en     <= 1'b0;
            done_pulse <= 1'b1;
          end
          default: st <= ST_MON;
        endcase
      end
    end
  end

  AST_ADDR_PAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_SPAR && !(m_ok && par_ok)) |=> (st == ST_MON && !ack_out)); // R2
  AST_UNICAST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_SPAR && !bcast_q && !addr_accept) |=> (st == ST_MON)); // R3
  AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_q && !frame_start) |-> !ack_out); // R4
  AST_CTRL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_CPAR && !(par_ok && ctrl_supported)) |=> (st == ST_MON)); // R5
  AST_BCAST_TO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_CACK) |=> (st == ST_LEN)); // R6
  AST_LEN_PAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st == ST_LPAR && !par_ok) |=> (st == ST_MON && !done_pulse)); // R7
  AST_ACK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (in_valid && is_ack_state(st))); // R8
  AST_DONE_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(step && st == ST_LACK)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R9
endmodule

// File: rtl/hdr_frame_rx.sv
module hdr_frame_rx #(
  parameter int ADDR_W = 12,
  parameter int GRP_W  = 4,
  parameter int CTRL_W = 4,
  parameter int LEN_W  = 8,
  parameter logic [2**CTRL_W-1:0] CTRL_OK_MASK = 16'hFFDB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              frame_start,
  input  logic              frame_bcast,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              ack_out,
  output logic              hdr_done,
  output logic [ADDR_W-1:0] hdr_master,
  output logic [ADDR_W-1:0] hdr_slave,
  output logic              hdr_bcast,
  output logic              hdr_general,
  output logic [GRP_W-1:0]  hdr_group,
  output logic [CTRL_W-1:0] hdr_ctrl,
  output logic [LEN_W:0]    hdr_len_bytes
);
  logic [ADDR_W-1:0] fld_value;
  logic              par_ok, addr_accept, is_general, ctrl_supported;
  logic [GRP_W-1:0]  group_id;
  logic              shift_en, clr, cap_master, cap_slave, cap_ctrl, cap_len;
  logic              done_load, bcast_q;

  logic [ADDR_W-1:0] master_q, slave_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  len_q;
  logic              general_q;
  logic [GRP_W-1:0]  group_q;

  hdr_bit_shifter #(.W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift_en), .bit_in(in_bit),
    .value(fld_value), .parity_ok(par_ok)
  );

  hdr_accept #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .CTRL_W(CTRL_W), .CTRL_OK_MASK(CTRL_OK_MASK)) u_acc (
    .bcast(bcast_q), .slave_addr(fld_value), .own_addr(own_addr),
    .ctrl_code(fld_value[CTRL_W-1:0]), .addr_accept(addr_accept),
    .is_general(is_general), .group_id(group_id), .ctrl_supported(ctrl_supported)
  );

  hdr_rx_seq #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_bcast(frame_bcast),
    .in_valid(in_valid), .par_ok(par_ok), .addr_accept(addr_accept),
    .ctrl_supported(ctrl_supported), .shift_en(shift_en), .clr(clr),
    .cap_master(cap_master), .cap_slave(cap_slave), .cap_ctrl(cap_ctrl),
    .cap_len(cap_len), .done_load(done_load), .done_pulse(hdr_done),
    .bcast_q(bcast_q), .ack_out(ack_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q  <= '0;
      slave_q   <= '0;
      ctrl_q    <= '0;
      len_q     <= '0;
      general_q <= 1'b0;
      group_q   <= '0;
    end else begin
      if (cap_master) master_q <= fld_value;
      if (cap_slave) begin
        slave_q   <= fld_value;
        general_q <= is_general;
        group_q   <= group_id;
      end
      if (cap_ctrl) ctrl_q <= fld_value[CTRL_W-1:0];
      if (cap_len)  len_q  <= fld_value[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_master    <= '0;
      hdr_slave     <= '0;
      hdr_bcast     <= 1'b0;
      hdr_general   <= 1'b0;
      hdr_group     <= '0;
      hdr_ctrl      <= '0;
      hdr_len_bytes <= '0;
    end else if (done_load) begin
      hdr_master    <= master_q;
      hdr_slave     <= slave_q;
      hdr_bcast     <= bcast_q;
      hdr_general   <= general_q;
      hdr_group     <= group_q;
      hdr_ctrl      <= ctrl_q;
      hdr_len_bytes <= (len_q == '0) ? (LEN_W+1)'(2**LEN_W) : {1'b0, len_q};
    end
  end

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_load |=> $stable(hdr_len_bytes) && $stable(hdr_slave)); // R9
  AST_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && (!hdr_bcast || hdr_general)) |-> (hdr_group == '0)); // R4
endmodule

// File: tb/hdr_frame_rx_tb.sv
module hdr_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] own_addr = 12'h3A5;
  logic        frame_start = 1'b0, frame_bcast = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic        ack_out, hdr_done, hdr_bcast, hdr_general;
  logic [11:0] hdr_master, hdr_slave;
  logic [3:0]  hdr_group, hdr_ctrl;
  logic [8:0]  hdr_len_bytes;

  int tests = 0, fails = 0;
  int done_cnt = 0, stray = 0;
  logic [2:0] acks;
  logic [11:0] d_master, d_slave;
  logic [3:0]  d_group, d_ctrl;
  logic [8:0]  d_len;
  logic        d_bcast, d_general;

  always #5 clk = ~clk;

  hdr_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .frame_start(frame_start),
    .frame_bcast(frame_bcast), .in_valid(in_valid), .in_bit(in_bit), .ack_out(ack_out),
    .hdr_done(hdr_done), .hdr_master(hdr_master), .hdr_slave(hdr_slave),
    .hdr_bcast(hdr_bcast), .hdr_general(hdr_general), .hdr_group(hdr_group),
    .hdr_ctrl(hdr_ctrl), .hdr_len_bytes(hdr_len_bytes)
  );

  always @(negedge clk) begin
    if (hdr_done) begin
      done_cnt++;
      d_master = hdr_master; d_slave = hdr_slave; d_bcast = hdr_bcast;
      d_general = hdr_general; d_group = hdr_group; d_ctrl = hdr_ctrl; d_len = hdr_len_bytes;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // one bit: starts at a negedge, returns at a negedge (or mid-gap if quick)
  task automatic send_bit(logic b, int slot, bit quick);
    in_valid = 1'b1; in_bit = b;
    #1;
    if (slot >= 0) acks[slot] = ack_out;
    else if (ack_out) stray++;
    @(negedge clk);
    in_valid = 1'b0;
    if (!quick) @(negedge clk);
  endtask

  task automatic send_field(logic [11:0] v, int w, logic bad_par, int slot, bit quick);
    logic p = 1'b0;
    for (int i = w - 1; i >= 0; i--) begin
      send_bit(v[i], -1, 1'b0);
      p ^= v[i];
    end
    send_bit(p ^ bad_par, -1, 1'b0);
    if (slot >= 0) send_bit(1'b1, slot, quick);
  endtask

  // bad = {master, slave, ctrl, len} parity corruption
  task automatic send_frame(logic bc, logic [11:0] m, logic [11:0] s, logic [3:0] c,
                            logic [7:0] l, logic [3:0] bad, bit quick);
    acks = 3'b000; stray = 0;
    frame_start = 1'b1; frame_bcast = bc;
    @(negedge clk);
    frame_start = 1'b0;
    send_field(m, 12, bad[3], -1, 1'b0);
    send_field(s, 12, bad[2], 2, 1'b0);
    send_field({8'h0, c}, 4, bad[1], 1, 1'b0);
    send_field({4'h0, l}, 8, bad[0], 0, quick);
  endtask

  task automatic t_reset();
    check("R8 reset ack_out", ack_out, 0);
    check("R9 reset hdr_done", hdr_done, 0);
  endtask

  task automatic t_unicast_ok();
    int d0 = done_cnt;
    send_frame(0, 12'h123, 12'h3A5, 4'h6, 8'h20, 4'b0000, 0);
    check("R3 unicast acks s/c/l", acks, 3'b111);
    check("R8 no stray ack", stray, 0);
    check("R9 done pulse", done_cnt - d0, 1);
    check("R9 master", d_master, 12'h123);
    check("R9 slave", d_slave, 12'h3A5);
    check("R9 ctrl", d_ctrl, 4'h6);
    check("R9 len", d_len, 9'd32);
    check("R9 group zero unicast", d_group, 0);
  endtask

  task automatic t_addr_par();
    int d0 = done_cnt;
    send_frame(0, 12'h123, 12'h3A5, 4'h6, 8'h20, 4'b1000, 0);
    check("R2 master parity bad acks", acks, 3'b000);
    check("R2 master parity no done", done_cnt - d0, 0);
    send_frame(0, 12'h123, 12'h3A5, 4'h6, 8'h20, 4'b0100, 0);
    check("R2 slave parity bad acks", acks, 3'b000);
    check("R2 slave parity no done", done_cnt - d0, 0);
    check("R8 no stray ack after abort", stray, 0);
  endtask

  task automatic t_mismatch();
    int d0 = done_cnt;
    send_frame(0, 12'h123, 12'h3A4, 4'h6, 8'h20, 4'b0000, 0);
    check("R3 mismatch acks", acks, 3'b000);
    check("R3 mismatch no done", done_cnt - d0, 0);
  endtask

  task automatic t_ctrl();
    int d0 = done_cnt;
    send_frame(0, 12'h0AA, 12'h3A5, 4'h6, 8'h10, 4'b0010, 0);
    check("R5 ctrl parity bad acks", acks, 3'b100);
    send_frame(0, 12'h0AA, 12'h3A5, 4'h2, 8'h10, 4'b0000, 0);
    check("R5 ctrl code 2 unsupported acks", acks, 3'b100);
    send_frame(0, 12'h0AA, 12'h3A5, 4'h5, 8'h10, 4'b0000, 0);
    check("R5 ctrl code 5 unsupported acks", acks, 3'b100);
    check("R5 no done on reject", done_cnt - d0, 0);
    send_frame(0, 12'h0AA, 12'h3A5, 4'hF, 8'h10, 4'b0000, 0);
    check("R5 code F supported acks", acks, 3'b111);
    check("R5 code F done", done_cnt - d0, 1);
  endtask

  task automatic t_bcast();
    int d0 = done_cnt;
    send_frame(1, 12'h777, 12'hFFF, 4'h3, 8'h05, 4'b0000, 0);
    check("R4 general no acks", acks, 3'b000);
    check("R6 general reaches done", done_cnt - d0, 1);
    check("R4 general flag", {d_bcast, d_general}, 2'b11);
    check("R4 general group zero", d_group, 0);
    send_frame(1, 12'h777, 12'h3C7, 4'h3, 8'h05, 4'b0000, 0);
    check("R4 group no acks", acks, 3'b000);
    check("R6 group reaches done", done_cnt - d0, 2);
    check("R4 group number", d_group, 4'h3);
    check("R4 group not general", d_general, 0);
    send_frame(1, 12'h777, 12'h5C7, 4'h3, 8'h05, 4'b0000, 0);
    check("R4 foreign group no done", done_cnt - d0, 2);
    send_frame(1, 12'h777, 12'hFFF, 4'h2, 8'h05, 4'b0000, 0);
    check("R5 bcast unsupported no done", done_cnt - d0, 2);
  endtask

  task automatic t_len();
    int d0 = done_cnt;
    send_frame(0, 12'h001, 12'h3A5, 4'h0, 8'h00, 4'b0000, 0);
    check("R9 len 0 is 256", d_len, 9'd256);
    check("R7 len ack", acks[0], 1);
    send_frame(0, 12'h001, 12'h3A5, 4'h0, 8'hFF, 4'b0001, 0);
    check("R7 len parity bad acks", acks, 3'b110);
    check("R7 len parity no done", done_cnt - d0, 1);
    check("R9 fields held", d_len, 9'd256);
    check("R9 held at port", hdr_len_bytes, 9'd256);
  endtask

  task automatic t_restart();
    int d0 = done_cnt;
    frame_start = 1'b1; frame_bcast = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 7; i++) send_bit(1'b1, -1, 1'b0);
    send_frame(0, 12'hABC, 12'h3A5, 4'h9, 8'h44, 4'b0000, 0);
    check("R1 restart acks", acks, 3'b111);
    check("R1 restart decode", d_master, 12'hABC);
    check("R1 restart done", done_cnt - d0, 1);
  endtask

  task automatic t_back_to_back();
    int d0 = done_cnt;
    send_frame(0, 12'h111, 12'h3A5, 4'h1, 8'h11, 4'b0000, 1);
    // frame_start now falls in the cycle where hdr_done is high
    check("R10 done visible at restart", hdr_done, 1);
    send_frame(0, 12'h222, 12'h3A5, 4'h4, 8'h22, 4'b0000, 0);
    check("R10 both done", done_cnt - d0, 2);
    check("R10 second decode master", d_master, 12'h222);
    check("R10 second decode len", d_len, 9'd34);
    check("R10 second acks", acks, 3'b111);
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unicast_ok();
    t_addr_par();
    t_mismatch();
    t_ctrl();
    t_bcast();
    t_len();
    t_restart();
    t_back_to_back();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule